// File: doc/BRIEF.md
# Gated Module Clock Divider

This block derives one module clock from a set of parent clocks. Each parent is presented inside a single fast system clock domain as a one-cycle qualifier pulse, the tick. The block picks one of these tick lanes, divides it by a power of two and then by a linear factor, and delivers the result as a one-cycle `mod_tick` pulse. Logic running on `clk` uses that pulse as the clock enable for the module domain.

Software controls the block through one 32-bit control word. The word holds an enable, a source select, a 2-bit power-of-two exponent P and a 4-bit linear factor M. The output rate is the selected tick rate divided by 2^P, then by M+1.

The block copies the programmed word into a working copy only at a period boundary. A boundary is one of three points: the end of a divided period, a cycle in which the counters are idle at zero, or any cycle while the working copy is disabled. As a result, a change of factors, source or enable never cuts a period short. One build option keeps the output permanently enabled. Another build option widens the source select from 4 to 16 lanes.

Top module: `modclk_divgate`

## Requirements
- R1: After reset the control word reads 0 and `mod_tick` is low. In the always-on build the word reads 0x8000_0000.
- R2: The readback fields are: enable at bit 31, source select at bits [24+SEL_W-1:24], P at bits [17:16] and M at bits [3:0]. Every other bit reads 0. Writing 0xFFFF_FFFF reads back 0x8303_000F with SEL_W=2 and 0x8F03_000F with SEL_W=4.
- R3: While enabled, exactly one `mod_tick` is produced for every 2^P*(M+1) ticks on the selected lane. The pulse is high for one cycle, in the cycle after the clock edge that samples the completing tick.
- R4: Ticks on lanes other than the selected one have no effect on `mod_tick`.
- R5: The output never runs faster than its parent. Each `mod_tick` follows a sampled tick on the selected lane. With P=0 and M=0, every selected tick yields a pulse.
- R6: A new P or M written in the middle of a period does not take effect until the current period has completed under the old factors.
- R7: Clearing the enable in the middle of a period still delivers that period's pulse. No pulse follows it.
- R8: While disabled, no `mod_tick` appears. Enabling from the disabled state starts counting from zero on the first cycle after the write has settled.
- R9: In the always-on build, the enable reads 1 at all times. A write that clears bit 31 has no effect on the enable, and pulses continue.
- R10: With SEL_W=4, source values up to 15 select the matching lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all parent ticks are qualified to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word readback, unused bits zero |
| src_tick | input | 2**SEL_W | One tick lane per parent clock |
| mod_tick | output | 1 | One-cycle pulse per divided module-clock period |

## Verification
The riskiest points are the moments when the configuration changes. The bench rewrites the factors halfway through a period and expects the pulse exactly on the old period's last tick, with the new ratio applying from the next tick on. A design that loads immediately would pulse early or late, producing a runt period. Clearing the enable halfway must still yield the pending pulse; a design that gates combinationally would drop it. Noise on every unselected lane exposes a select that indexes the wrong lane. The largest ratio, 128, exposes an exponent or counter that is one bit short. The always-on build receives a write that clears the enable, and its pulses must continue.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
  localparam int REG_W   = 32;
  localparam int M_LSB   = 0;
  localparam int M_W     = 4;
  localparam int P_LSB   = 16;
  localparam int P_W     = 2;
  localparam int SEL_LSB = 24;
  localparam int EN_BIT  = 31;
  // widest pre-divider count is 2**(2**P_W - 1) - 1, which needs (2**P_W - 1) bits
  localparam int PRE_CW  = (1 << P_W) - 1;

  // last count value of the power-of-two stage: 2**p - 1
  function automatic logic [PRE_CW-1:0] pre_last(input logic [P_W-1:0] p);
    logic [PRE_CW:0] span;
    span = {{PRE_CW{1'b0}}, 1'b1} << p;
    span = span - {{PRE_CW{1'b0}}, 1'b1};
    return span[PRE_CW-1:0];
  endfunction

  // bits of the control word that carry a field for a given select width
  function automatic logic [REG_W-1:0] used_mask(input int sel_w);
    logic [REG_W-1:0] msk;
    msk = '0;
    msk[EN_BIT] = 1'b1;
    for (int i = 0; i < sel_w; i++) msk[SEL_LSB+i] = 1'b1;
    for (int i = 0; i < P_W; i++)   msk[P_LSB+i]   = 1'b1;
    for (int i = 0; i < M_W; i++)   msk[M_LSB+i]   = 1'b1;
    return msk;
  endfunction
endpackage

// File: rtl/modclk_cfg_reg.sv
module modclk_cfg_reg
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             cfg_en,
  output logic [SEL_W-1:0] cfg_sel,
  output logic [P_W-1:0]   cfg_p,
  output logic [M_W-1:0]   cfg_m,
  output logic [REG_W-1:0] rd_data
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel <= '0;
      cfg_p   <= '0;
      cfg_m   <= '0;
    end else if (wr_en) begin
      cfg_sel <= wr_data[SEL_LSB +: SEL_W];
      cfg_p   <= wr_data[P_LSB +: P_W];
      cfg_m   <= wr_data[M_LSB +: M_W];
    end
  end

  generate
    if (ALWAYS_ON) begin : g_pinned_on
      assign cfg_en = 1'b1;
    end else begin : g_sw_enable
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_en <= 1'b0;
        else if (wr_en) cfg_en <= wr_data[EN_BIT];
      end
    end
  endgenerate

  always_comb begin
    rd_data                   = '0;
    rd_data[EN_BIT]           = cfg_en;
    rd_data[SEL_LSB +: SEL_W] = cfg_sel;
    rd_data[P_LSB +: P_W]     = cfg_p;
    rd_data[M_LSB +: M_W]     = cfg_m;
  end
endmodule

// File: rtl/modclk_div_core.sv
module modclk_div_core
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int NSRC  = 1 << SEL_W,
  localparam int ACT_W = 1 + SEL_W + P_W + M_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [P_W-1:0]   cfg_p,
  input  logic [M_W-1:0]   cfg_m,
  input  logic [NSRC-1:0]  src_tick,
  output logic             mod_tick,
  output logic             src_hit,
  output logic             at_boundary,
  output logic             act_en,
  output logic [ACT_W-1:0] act_word
);
  logic [SEL_W-1:0]  act_sel;
  logic [P_W-1:0]    act_p;
  logic [M_W-1:0]    act_m;
  logic [PRE_CW-1:0] pre_cnt;
  logic [M_W-1:0]    lin_cnt;
  logic              pre_wrap;
  logic              period_done;
  logic              at_zero;

  assign src_hit     = act_en & src_tick[act_sel];
  assign pre_wrap    = src_hit & (pre_cnt == pre_last(act_p));
  assign period_done = pre_wrap & (lin_cnt == act_m);
  assign at_zero     = (pre_cnt == '0) & (lin_cnt == '0) & ~src_hit;
  assign at_boundary = ~act_en | period_done | at_zero;
  assign act_word    = {act_en, act_sel, act_p, act_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_sel  <= '0;
      act_p    <= '0;
      act_m    <= '0;
      pre_cnt  <= '0;
      lin_cnt  <= '0;
      mod_tick <= 1'b0;
    end else begin
      mod_tick <= period_done;
      if (at_boundary) begin
        act_en  <= cfg_en;
        act_sel <= cfg_sel;
        act_p   <= cfg_p;
        act_m   <= cfg_m;
        pre_cnt <= '0;
        lin_cnt <= '0;
      end else if (src_hit) begin
        if (pre_wrap) begin
          pre_cnt <= '0;
          lin_cnt <= lin_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modclk_divgate.sv
module modclk_divgate
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0,
  localparam int NSRC     = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  src_tick,
  output logic             mod_tick
);
  localparam int ACT_W = 1 + SEL_W + P_W + M_W;

  logic             cfg_en;
  logic [SEL_W-1:0] cfg_sel;
  logic [P_W-1:0]   cfg_p;
  logic [M_W-1:0]   cfg_m;
  logic             src_hit;
  logic             at_boundary;
  logic             act_en;
  logic [ACT_W-1:0] act_word;

  modclk_cfg_reg #(.SEL_W(SEL_W), .ALWAYS_ON(ALWAYS_ON)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_en  (cfg_en),
    .cfg_sel (cfg_sel),
    .cfg_p   (cfg_p),
    .cfg_m   (cfg_m),
    .rd_data (rd_data)
  );

  modclk_div_core #(.SEL_W(SEL_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_sel     (cfg_sel),
    .cfg_p       (cfg_p),
    .cfg_m       (cfg_m),
    .src_tick    (src_tick),
    .mod_tick    (mod_tick),
    .src_hit     (src_hit),
    .at_boundary (at_boundary),
    .act_en      (act_en),
    .act_word    (act_word)
  );
endmodule

// File: rtl/modclk_divgate_chk.sv
module modclk_divgate_chk
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0,
  localparam int ACT_W    = 1 + SEL_W + P_W + M_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_data,
  input logic             mod_tick,
  input logic             src_hit,
  input logic             at_boundary,
  input logic             act_en,
  input logic [ACT_W-1:0] act_word
);
  localparam logic [REG_W-1:0] RSVD = ~used_mask(SEL_W);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD) == '0); // R2

  AST_PULSE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick |-> $past(src_hit)); // R5

  AST_SHADOW_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(at_boundary) |-> $stable(act_word)); // R6

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act_en) |-> !mod_tick); // R8

  AST_KEEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ALWAYS_ON |-> rd_data[EN_BIT]); // R9
endmodule

bind modclk_divgate modclk_divgate_chk #(.SEL_W(SEL_W), .ALWAYS_ON(ALWAYS_ON)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_data     (rd_data),
  .mod_tick    (mod_tick),
  .src_hit     (src_hit),
  .at_boundary (at_boundary),
  .act_en      (act_en),
  .act_word    (act_word)
);

// File: tb/modclk_divgate_bench.sv
module modclk_divgate_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [31:0] wd_a = '0, wd_b = '0, rd_a, rd_b;
  logic [3:0]  src_a = '0;
  logic [15:0] src_b = '0;
  logic        mod_a, mod_b;
  logic [15:0] lfsr = 16'hACE1;
  int          vectors = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  modclk_divgate u_modclk_divgate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_data(wd_a),
    .rd_data(rd_a), .src_tick(src_a), .mod_tick(mod_a));

  modclk_divgate #(.SEL_W(4), .ALWAYS_ON(1'b1)) u_modclk_divgate_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_data(wd_b),
    .rd_data(rd_b), .src_tick(src_b), .mod_tick(mod_b));

  function automatic logic [31:0] word(bit en, int sel, int p, int m);
    return (32'(en) << 31) | (32'(sel) << 24) | (32'(p) << 16) | 32'(m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write, then one quiet cycle so an idle block can adopt the word
  task automatic write(bit use_b, logic [31:0] v);
    @(negedge clk);
    src_a = '0; src_b = '0;
    if (use_b) begin wr_b = 1'b1; wd_b = v; end
    else       begin wr_a = 1'b1; wd_a = v; end
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic cycle(bit use_b, int sel, bit hit, bit noisy, output logic seen);
    logic [15:0] pat;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pat = noisy ? lfsr : 16'h0;
    pat[sel] = hit;
    if (use_b) src_b = pat; else src_a = pat[3:0];
    @(posedge clk); #1;
    seen = use_b ? mod_b : mod_a;
  endtask

  // n = ratio (0 = no pulse expected), start = ticks already in the period
  task automatic run(bit use_b, int sel, int n, int start, int ticks, int gap, string req);
    logic seen;
    for (int i = 1; i <= ticks; i++) begin
      cycle(use_b, sel, 1'b1, 1'b1, seen);
      check(req, 32'(seen), (n != 0 && (start + i) % n == 0) ? 32'd1 : 32'd0);
      for (int g = 0; g < gap; g++) begin
        cycle(use_b, sel, 1'b0, 1'b1, seen);
        check(req, 32'(seen), 32'd0);
      end
    end
  endtask

  task automatic t_reset();
    check("R1", rd_a, 32'h0);
    check("R1", 32'(mod_a), 32'h0);
    check("R1", rd_b, 32'h8000_0000);
  endtask

  task automatic t_enable();
    run(1'b0, 0, 0, 0, 6, 1, "R8");
    write(1'b0, word(1'b1, 0, 0, 4));
    run(1'b0, 0, 5, 0, 10, 1, "R8");
  endtask

  task automatic t_readback();
    write(1'b0, 32'hFFFF_FFFF);
    check("R2", rd_a, 32'h8303_000F);
    write(1'b0, 32'h7CFC_FFF0);
    check("R2", rd_a, 32'h0);
    write(1'b1, 32'hFFFF_FFFF);
    check("R2", rd_b, 32'h8F03_000F);
    write(1'b1, 32'h0);
  endtask

  task automatic t_ratios();
    write(1'b0, word(1'b1, 2, 1, 2));
    run(1'b0, 2, 6, 0, 12, 1, "R3");
    write(1'b0, word(1'b1, 1, 3, 15));
    run(1'b0, 1, 128, 0, 256, 0, "R3");
    write(1'b0, word(1'b1, 0, 2, 4));
    run(1'b0, 0, 20, 0, 40, 2, "R3");
  endtask

  task automatic t_full_rate();
    write(1'b0, word(1'b1, 3, 0, 0));
    run(1'b0, 3, 1, 0, 10, 0, "R5");
  endtask

  task automatic t_lane_noise();
    logic seen;
    write(1'b0, word(1'b1, 1, 0, 1));
    run(1'b0, 1, 2, 0, 10, 1, "R4");
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, 1, 1'b0, 1'b1, seen);
      check("R4", 32'(seen), 32'd0);
    end
    run(1'b0, 1, 2, 0, 4, 0, "R4");
  endtask

  task automatic t_mid_change();
    write(1'b0, word(1'b1, 3, 1, 1));
    run(1'b0, 3, 4, 0, 2, 1, "R6");
    write(1'b0, word(1'b1, 3, 0, 2));
    run(1'b0, 3, 4, 2, 2, 1, "R6");
    run(1'b0, 3, 3, 0, 6, 1, "R6");
  endtask

  task automatic t_mid_disable();
    write(1'b0, word(1'b1, 3, 1, 1));
    run(1'b0, 3, 4, 0, 2, 0, "R7");
    write(1'b0, word(1'b0, 3, 1, 1));
    run(1'b0, 3, 4, 2, 2, 0, "R7");
    run(1'b0, 3, 0, 0, 8, 1, "R7");
  endtask

  task automatic t_always_on();
    run(1'b1, 0, 1, 0, 4, 1, "R9");
    write(1'b1, word(1'b0, 0, 0, 0));
    check("R9", rd_b, 32'h8000_0000);
    run(1'b1, 0, 1, 0, 4, 1, "R9");
  endtask

  task automatic t_wide_select();
    write(1'b1, word(1'b0, 15, 0, 1));
    check("R10", rd_b, 32'h8F00_0001);
    run(1'b1, 15, 2, 0, 8, 1, "R10");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_enable();
    t_readback();
    t_ratios();
    t_full_rate();
    t_lane_noise();
    t_mid_change();
    t_mid_disable();
    t_always_on();
    t_wide_select();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule